// File: doc/BRIEF.md
# Data Translation Buffer Lookup with Fault Classification

This block is the data-side address translation buffer of a 32-bit core that uses 4 KB pages. It holds a small set of fully associative entries. On every data access it compares the access's virtual page number against all of them at once. An entry can only match when it is valid and either is shared by all processes or carries the current process tag.

When an entry matches, the block checks the access kind against the entry's read and write permissions. A successful access yields a physical address built from the entry's frame number and the untranslated page offset. A failed check yields a read or a write violation code. A cache-flush access uses the translation without any permission check. When no entry matches, the block reports one of two miss classes. Which one depends on whether the core is already running a fault handler.

Software fills entries through a single indexed write port. The result of each lookup is registered and appears one cycle after the request.

Top module: `dtlb_lookup`

## Requirements
- R1: An entry matches only when its valid bit is 1, its 20-bit page number equals `req_vaddr[31:12]`, and either its global bit is 1 or its 8-bit process tag equals `cur_pid`. An entry written with `wr_valid`=0 never matches.
- R2: The access kind is encoded as 0 = load, 1 = store, 2 = cache flush, 3 = treated as load. On a match, a load needs the read bit and a store needs the write bit. A load that fails gives code 1 (read violation). A store that fails gives code 2 (write violation).
- R3: A cache-flush access that matches produces code 0 and a translated address whatever the read and write bits hold.
- R4: On code 0 the physical address is the matching entry's 20-bit frame number placed above `req_vaddr[11:0]`. For any nonzero code the physical address is 0.
- R5: When no entry matches, the code is 4 (double miss) if `in_handler` was 1 with the request, and 3 (fast miss) otherwise.
- R6: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1. With `req_valid`=0, the next cycle shows `rsp_valid`=0, code 0 and address 0.
- R7: A write with `wr_en`=1 updates entry `wr_idx` at the clock edge. A lookup issued in the same cycle still sees the entry's previous contents.
- R8: When several entries match, the lowest-numbered one supplies the frame and the permissions.
- R9: A synchronous reset with `rst`=1 clears every valid bit and `rsp_valid`, so every later lookup misses until entries are written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Lookup request this cycle |
| req_vaddr | input | 32 | Virtual address of the access |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 flush, 3 load |
| cur_pid | input | 8 | Current process tag |
| in_handler | input | 1 | Core is already inside a fault handler |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_pfn | input | 20 | Physical frame number to store |
| wr_pid | input | 8 | Process tag to store |
| wr_global | input | 1 | Entry is shared by all processes |
| wr_read | input | 1 | Loads permitted |
| wr_write | input | 1 | Stores permitted |
| wr_valid | input | 1 | Entry valid |
| rsp_valid | output | 1 | Registered result valid |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_exc | output | 3 | Fault code: 0 none, 1 read, 2 write, 3 fast miss, 4 double miss |

## Verification
The two functions that can land in one cycle are an entry update and a lookup that hits the same entry. The bench issues a write to an index together with a request for the page that the write is about to install. It expects a miss in that cycle and a hit on the following request. It also overwrites the lowest of two duplicate entries while looking up their shared page, and expects the old lowest entry's frame first and the higher entry's frame afterwards. Every result is predicted from a separate entry model kept in the bench, taken before that model applies the write.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FLUSH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    EXC_NONE      = 3'd0,
    EXC_RD_VIOL   = 3'd1,
    EXC_WR_VIOL   = 3'd2,
    EXC_FAST_MISS = 3'd3,
    EXC_DBL_MISS  = 3'd4
  } exc_code_e;

  // Permission outcome for a matching entry.
  function automatic logic perm_granted(acc_kind_e kind, logic rd_ok, logic wr_ok);
    logic g;
    case (kind)
      ACC_STORE: g = wr_ok;
      ACC_FLUSH: g = 1'b1;
      default:   g = rd_ok;
    endcase
    return g;
  endfunction

  // Fault class from match, permission and handler state.
  function automatic exc_code_e classify(logic hit, logic granted, logic in_hnd,
                                         acc_kind_e kind);
    exc_code_e c;
    if (!hit)
      c = in_hnd ? EXC_DBL_MISS : EXC_FAST_MISS;
    else if (granted)
      c = EXC_NONE;
    else if (kind == ACC_STORE)
      c = EXC_WR_VIOL;
    else
      c = EXC_RD_VIOL;
    return c;
  endfunction

endpackage

// File: rtl/dtlb_entry_store.sv
module dtlb_entry_store #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [VPN_W-1:0]               wr_vpn,
  input  logic [PFN_W-1:0]               wr_pfn,
  input  logic [PID_W-1:0]               wr_pid,
  input  logic                           wr_global,
  input  logic                           wr_read,
  input  logic                           wr_write,
  input  logic                           wr_valid,
  output logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  output logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn,
  output logic [ENTRIES-1:0][PID_W-1:0]  ent_pid,
  output logic [ENTRIES-1:0]             ent_glb,
  output logic [ENTRIES-1:0]             ent_rd,
  output logic [ENTRIES-1:0]             ent_wr,
  output logic [ENTRIES-1:0]             ent_vld
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel_this;
    assign sel_this = wr_en && (wr_idx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_vld[e] <= 1'b0;
      end else if (sel_this) begin
        ent_vld[e] <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_this) begin
        ent_vpn[e] <= wr_vpn;
        ent_pfn[e] <= wr_pfn;
        ent_pid[e] <= wr_pid;
        ent_glb[e] <= wr_global;
        ent_rd[e]  <= wr_read;
        ent_wr[e]  <= wr_write;
      end
    end
  end

  // R9
  reset_clears_valid_chk: assert property (@(posedge clk) rst |=> (ent_vld == '0));

  // R7
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ent_vld[$past(wr_idx)] == $past(wr_valid)) &&
              (ent_vpn[$past(wr_idx)] == $past(wr_vpn)) &&
              (ent_pfn[$past(wr_idx)] == $past(wr_pfn)));

endmodule

// File: rtl/dtlb_match.sv
module dtlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [VPN_W-1:0]               req_vpn,
  input  logic [PID_W-1:0]               cur_pid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [ENTRIES-1:0][PID_W-1:0]  ent_pid,
  input  logic [ENTRIES-1:0]             ent_glb,
  input  logic [ENTRIES-1:0]             ent_vld,
  output logic                           hit_any,
  output logic [IDX_W-1:0]               hit_idx
);

  logic [ENTRIES-1:0] hit_vec;   // raw per-entry match
  logic [ENTRIES-1:0] lower_hit; // some lower entry matched
  logic [ENTRIES-1:0] grant_oh;  // lowest match only

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic tag_eq;
    logic owner_ok;
    assign tag_eq   = (ent_vpn[e] == req_vpn);
    assign owner_ok = ent_glb[e] || (ent_pid[e] == cur_pid);
    assign hit_vec[e] = ent_vld[e] && tag_eq && owner_ok;

    if (e == 0) begin : g_first
      assign lower_hit[e] = 1'b0;
    end else begin : g_rest
      assign lower_hit[e] = lower_hit[e-1] | hit_vec[e-1];
    end
    assign grant_oh[e] = hit_vec[e] & ~lower_hit[e];
  end

  assign hit_any = |grant_oh;

  always_comb begin
    hit_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (grant_oh[e]) hit_idx = hit_idx | IDX_W'(e);
    end
  end

  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_oh));

  // R8
  grant_covers_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit_vec) == hit_any);

  // R1
  granted_entry_valid_chk: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> ent_vld[hit_idx] && (ent_vpn[hit_idx] == req_vpn));

endmodule

// File: rtl/dtlb_respond.sv
module dtlb_respond #(
  parameter int PFN_W  = 20,
  parameter int OFFS_W = 12,
  localparam int PA_W  = PFN_W + OFFS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         req_kind,
  input  logic [OFFS_W-1:0]  req_offs,
  input  logic               in_handler,
  input  logic               hit_any,
  input  logic               sel_rd,
  input  logic               sel_wr,
  input  logic [PFN_W-1:0]   sel_pfn,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [2:0]         rsp_exc
);
  import dtlb_pkg::*;

  acc_kind_e kind;
  logic      granted;
  exc_code_e exc_n;
  logic [PA_W-1:0] pa_n;

  assign kind    = acc_kind_e'(req_kind);
  assign granted = perm_granted(kind, sel_rd, sel_wr);
  assign exc_n   = classify(hit_any, granted, in_handler, kind);
  assign pa_n    = (exc_n == EXC_NONE) ? {sel_pfn, req_offs} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_exc   <= 3'd0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_exc   <= req_valid ? 3'(exc_n) : 3'd0;
      rsp_paddr <= req_valid ? pa_n : '0;
    end
  end

  // R6
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R6
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && (rsp_exc == 3'd0) && (rsp_paddr == '0));

  // R5
  miss_class_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !hit_any |=> rsp_exc == ($past(in_handler) ? 3'd4 : 3'd3));

  // R4
  pa_zero_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_exc != 3'd0) |-> (rsp_paddr == '0));

  // R3
  flush_no_viol_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && hit_any && (req_kind == 2'd2) |=> (rsp_exc == 3'd0));

  // R2
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_exc <= 3'd4);

endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int PID_W   = 8,
  parameter int OFFS_W  = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFFS_W,
  localparam int PA_W   = PFN_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic [PID_W-1:0]  cur_pid,
  input  logic              in_handler,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic              wr_global,
  input  logic              wr_read,
  input  logic              wr_write,
  input  logic              wr_valid,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [2:0]        rsp_exc
);

  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
  logic [ENTRIES-1:0][PFN_W-1:0] ent_pfn;
  logic [ENTRIES-1:0][PID_W-1:0] ent_pid;
  logic [ENTRIES-1:0]            ent_glb;
  logic [ENTRIES-1:0]            ent_rd;
  logic [ENTRIES-1:0]            ent_wr;
  logic [ENTRIES-1:0]            ent_vld;

  logic              hit_any;
  logic [IDX_W-1:0]  hit_idx;
  logic [PFN_W-1:0]  sel_pfn;
  logic              sel_rd;
  logic              sel_wr;

  dtlb_entry_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pfn(wr_pfn),
    .wr_pid(wr_pid), .wr_global(wr_global), .wr_read(wr_read),
    .wr_write(wr_write), .wr_valid(wr_valid),
    .ent_vpn(ent_vpn), .ent_pfn(ent_pfn), .ent_pid(ent_pid),
    .ent_glb(ent_glb), .ent_rd(ent_rd), .ent_wr(ent_wr), .ent_vld(ent_vld)
  );

  dtlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)
  ) u_match (
    .clk(clk), .rst(rst),
    .req_vpn(req_vaddr[VA_W-1:OFFS_W]), .cur_pid(cur_pid),
    .ent_vpn(ent_vpn), .ent_pid(ent_pid), .ent_glb(ent_glb), .ent_vld(ent_vld),
    .hit_any(hit_any), .hit_idx(hit_idx)
  );

  assign sel_pfn = ent_pfn[hit_idx];
  assign sel_rd  = ent_rd[hit_idx];
  assign sel_wr  = ent_wr[hit_idx];

  dtlb_respond #(
    .PFN_W(PFN_W), .OFFS_W(OFFS_W)
  ) u_resp (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_kind(req_kind),
    .req_offs(req_vaddr[OFFS_W-1:0]), .in_handler(in_handler),
    .hit_any(hit_any), .sel_rd(sel_rd), .sel_wr(sel_wr), .sel_pfn(sel_pfn),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_exc(rsp_exc)
  );

endmodule

// File: tb/test_dtlb_lookup.sv
`timescale 1ns/1ps
module test_dtlb_lookup;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic [7:0]  cur_pid;
  logic        in_handler;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [19:0] wr_vpn, wr_pfn;
  logic [7:0]  wr_pid;
  logic        wr_global, wr_read, wr_write, wr_valid;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_exc;

  always #2.5 clk = ~clk;

  dtlb_lookup i_dtlb_lookup (.*);

  typedef struct {
    bit        v;
    bit [31:0] pa;
    bit [2:0]  exc;
    string     tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   mon_on = 0;

  // Reference entry model
  bit [19:0] m_vpn[16], m_pfn[16];
  bit [7:0]  m_pid[16];
  bit        m_g[16], m_r[16], m_w[16], m_v[16];

  // Staged write for the next step
  bit        st_we = 0;
  bit [3:0]  st_idx;
  bit [19:0] st_vpn, st_pfn;
  bit [7:0]  st_pid;
  bit        st_g, st_r, st_w, st_v;

  function automatic exp_t predict(bit [31:0] va, bit [1:0] kind, bit [7:0] pid,
                                   bit hnd, string tag);
    exp_t e;
    int   sel = -1;
    bit   ok;
    for (int i = 15; i >= 0; i--) begin
      if (m_v[i] && m_vpn[i] == va[31:12] && (m_g[i] || m_pid[i] == pid)) sel = i;
    end
    e.v = 1; e.tag = tag; e.pa = 0;
    if (sel < 0) begin
      e.exc = hnd ? 3'd4 : 3'd3;
    end else begin
      if (kind == 2'd2)      ok = 1;
      else if (kind == 2'd1) ok = m_w[sel];
      else                   ok = m_r[sel];
      if (ok) begin
        e.exc = 0;
        e.pa  = {m_pfn[sel], va[11:0]};
      end else begin
        e.exc = (kind == 2'd1) ? 3'd2 : 3'd1;
      end
    end
    return e;
  endfunction

  task automatic stage_wr(bit [3:0] idx, bit [19:0] vpn, bit [19:0] pfn, bit [7:0] pid,
                          bit g, bit r, bit w, bit v);
    st_we = 1; st_idx = idx; st_vpn = vpn; st_pfn = pfn; st_pid = pid;
    st_g = g; st_r = r; st_w = w; st_v = v;
  endtask

  task automatic step(bit rq, bit [31:0] va, bit [1:0] kind, bit [7:0] pid, bit hnd,
                      string tag);
    exp_t e;
    @(negedge clk);
    req_valid = rq; req_vaddr = va; req_kind = kind; cur_pid = pid; in_handler = hnd;
    wr_en = st_we; wr_idx = st_idx; wr_vpn = st_vpn; wr_pfn = st_pfn; wr_pid = st_pid;
    wr_global = st_g; wr_read = st_r; wr_write = st_w; wr_valid = st_v;
    if (rq) e = predict(va, kind, pid, hnd, tag);
    else begin e.v = 0; e.pa = 0; e.exc = 0; e.tag = tag; end
    if (mon_on) sb_q.push_back(e);
    if (st_we) begin
      m_vpn[st_idx] = st_vpn; m_pfn[st_idx] = st_pfn; m_pid[st_idx] = st_pid;
      m_g[st_idx] = st_g; m_r[st_idx] = st_r; m_w[st_idx] = st_w; m_v[st_idx] = st_v;
    end
    st_we = 0;
  endtask

  task automatic fill(bit [3:0] idx, bit [19:0] vpn, bit [19:0] pfn, bit [7:0] pid,
                      bit g, bit r, bit w, bit v);
    stage_wr(idx, vpn, pfn, pid, g, r, w, v);
    step(0, 0, 0, 0, 0, "R7");
  endtask

  // Monitor: compares one result per cycle after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (rsp_valid !== e.v || rsp_paddr !== e.pa || rsp_exc !== e.exc) begin
          n_fail++;
          $display("FAIL %s: got v=%0b pa=%h exc=%0d, expected v=%0b pa=%h exc=%0d",
                   e.tag, rsp_valid, rsp_paddr, rsp_exc, e.v, e.pa, e.exc);
        end
      end
    end
  end

  task automatic check_idle_reset(string tag);
    @(posedge clk); #1;
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: rsp_valid got %0b expected 0", tag, rsp_valid);
    end
  endtask

  task automatic drain();
    @(posedge clk); #2;
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_v[i] = 0;
    rst = 1; req_valid = 1; req_vaddr = 0; req_kind = 0; cur_pid = 0; in_handler = 0;
    wr_en = 0; wr_idx = 0; wr_vpn = 0; wr_pfn = 0; wr_pid = 0;
    wr_global = 0; wr_read = 0; wr_write = 0; wr_valid = 0;
    repeat (2) @(posedge clk);
    check_idle_reset("R9 reset state");
    @(negedge clk); rst = 0; req_valid = 0;
    mon_on = 1;

    // Populate
    fill(4'd0, 20'h0000A, 20'hA1A1A, 8'd5, 0, 1, 0, 1); // read only, pid 5
    fill(4'd1, 20'h0000B, 20'hB2B2B, 8'd1, 1, 1, 1, 1); // global RW
    fill(4'd2, 20'h0000C, 20'hC3C3C, 8'd7, 0, 0, 1, 1); // write only, pid 7
    fill(4'd3, 20'h0000D, 20'hD4D4D, 8'd5, 1, 1, 1, 0); // invalid
    fill(4'd5, 20'h0000E, 20'hE5E5E, 8'd0, 1, 1, 1, 1); // duplicate low
    fill(4'd9, 20'h0000E, 20'hE9E9E, 8'd0, 1, 1, 1, 1); // duplicate high

    step(0, 0, 0, 0, 0, "R6 idle");
    step(1, 32'h0000A123, 2'd0, 8'd5, 0, "R4 load hit translate");
    step(1, 32'h0000AFFF, 2'd0, 8'd6, 0, "R1 pid mismatch fast miss");
    step(1, 32'h0000A000, 2'd0, 8'd6, 1, "R5 double miss in handler");
    step(1, 32'h0000A010, 2'd0, 8'd6, 0, "R5 fast miss");
    step(1, 32'h0000A456, 2'd1, 8'd5, 0, "R2 store write violation");
    step(1, 32'h0000C456, 2'd0, 8'd7, 0, "R2 load read violation");
    step(1, 32'h0000C789, 2'd1, 8'd7, 0, "R2 store permitted");
    step(1, 32'h0000C789, 2'd3, 8'd7, 1, "R2 kind 3 as load");
    step(1, 32'h0000A321, 2'd2, 8'd5, 0, "R3 flush on read-only");
    step(1, 32'h0000C321, 2'd2, 8'd7, 0, "R3 flush on write-only");
    step(1, 32'h0000B0F0, 2'd1, 8'd99, 0, "R1 global match");
    step(1, 32'h0000D000, 2'd0, 8'd5, 0, "R1 invalid entry misses");
    step(1, 32'h0000EABC, 2'd0, 8'd3, 0, "R8 lowest duplicate wins");
    step(0, 32'h0000EABC, 2'd0, 8'd3, 0, "R6 no request");

    // Write and lookup in the same cycle
    stage_wr(4'd0, 20'h0000F, 20'hF0F0F, 8'd2, 0, 1, 1, 1);
    step(1, 32'h0000F111, 2'd0, 8'd2, 0, "R7 same-cycle write unseen");
    step(1, 32'h0000F222, 2'd1, 8'd2, 0, "R7 write seen next cycle");
    step(1, 32'h0000A123, 2'd0, 8'd5, 1, "R7 replaced entry gone");
    stage_wr(4'd5, 20'h0000E, 20'h00000, 8'd0, 1, 1, 1, 0);
    step(1, 32'h0000E555, 2'd2, 8'd3, 0, "R8 old low entry still used");
    step(1, 32'h0000E666, 2'd0, 8'd3, 0, "R8 next entry after invalidate");
    drain();

    // Reset wipes entries
    mon_on = 0;
    @(negedge clk); rst = 1;
    check_idle_reset("R9 reset mid-run");
    @(negedge clk); rst = 0;
    for (int i = 0; i < 16; i++) m_v[i] = 0;
    mon_on = 1;
    step(1, 32'h0000B0F0, 2'd0, 8'd1, 0, "R9 global entry cleared");
    step(1, 32'h0000F222, 2'd2, 8'd2, 1, "R9 cleared double miss");
    step(0, 0, 0, 0, 0, "R6 idle end");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule